// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block judges, in a single combinational step, whether a selector and the attributes of its already-fetched descriptor may be placed into one of the six segment registers of a 64-bit-mode core. It reports either acceptance or a fault. A fault is classified as a general-protection fault or a segment-not-present fault. The block also owns the current privilege level (CPL) register, which changes only when a code-segment load into CS is accepted.

The surrounding load pipeline presents a request with `load_valid` high. The request carries the target register, the selector fields (index, table indicator, requested privilege) and the descriptor attributes (system/user flag, a three-bit kind field, descriptor privilege, present flag). The pipeline reads the verdict in the same cycle. Descriptor fetch, gates and task switching happen elsewhere. The rules differ by target. CS takes only code. SS takes only writable data at exactly the current privilege. The four data registers accept a null selector and apply readability and privilege rules to everything else.

Top module: `seg_load_guard`

## Requirements
- R1: While `load_valid` is low, `load_ok` and `fault` are 0, `fault_code` is 2'b00 and `cpl` does not change.
- R2: `seg_target` codes are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. Codes 6 and 7 always yield a general-protection fault.
- R3: A selector is null when index is 0 and the table indicator is 0. A null load into ES, DS, FS or GS is accepted whatever the descriptor attributes are, including a clear present flag. A null load into CS or SS is a general-protection fault. Index 0 with table indicator 1 is not null.
- R4: A CS load is accepted only for a code descriptor: `desc_user`=1 and `desc_kind[2]`=1. Anything else is a general-protection fault.
- R5: `cpl` resets to 0. On the clock edge after an accepted CS load, `cpl` equals that descriptor's `desc_dpl`. After any other cycle it holds.
- R6: An SS load needs a writable data descriptor: `desc_user`=1, `desc_kind[2]`=0 and `desc_kind[0]`=1. Anything else is a general-protection fault.
- R7: An SS load needs `desc_dpl` equal to `cpl` and `sel_rpl` equal to `cpl`. Otherwise it is a general-protection fault.
- R8: A non-null data-register load faults (general protection) for a system descriptor (`desc_user`=0). It also faults for a code descriptor whose readable bit `desc_kind[0]` is 0.
- R9: For a non-null data-register load of a data descriptor, or of a conforming code descriptor (`desc_kind[2:1]`=2'b11), `desc_dpl` must be at least the larger of `cpl` and `sel_rpl`. Otherwise it is a general-protection fault. A non-conforming readable code descriptor has no privilege test.
- R10: When every type and privilege rule passes but `desc_present` is 0, the result is a segment-not-present fault. Any general-protection condition takes priority over it.
- R11: `fault_code` encodes 2'b00 for no fault, 2'b01 for general protection and 2'b10 for not present. For a valid request, exactly one of `load_ok` and `fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | A load request is present this cycle |
| seg_target | input | 3 | Destination segment register code |
| sel_index | input | IDX_W | Selector table index |
| sel_ti | input | 1 | Selector table indicator |
| sel_rpl | input | 2 | Selector requested privilege |
| desc_user | input | 1 | Descriptor is code/data (1) or system (0) |
| desc_kind | input | 3 | [2] executable, [1] conforming/expand-down, [0] readable/writable |
| desc_dpl | input | 2 | Descriptor privilege |
| desc_present | input | 1 | Descriptor present flag |
| load_ok | output | 1 | Load accepted |
| fault | output | 1 | Load rejected |
| fault_code | output | 2 | Fault class |
| cpl | output | 2 | Current privilege level |

## Verification
The hardest situations to reach are those that need a particular privilege already held. Two examples are an SS load at privilege 3 and a data load where `sel_rpl` and `cpl` disagree. The block offers no direct way to set the privilege, so the bench first issues an accepted CS load whose descriptor privilege is the one it wants. It confirms the privilege took effect and only then applies the vector under test. The same path covers the ordering corner where a privilege violation and a clear present flag occur together and the general-protection fault must win.

// File: rtl/seg_guard_pkg.sv
// Package: shared encodings and records for the segment load checker.
// Assumes a three-bit target code; slots beyond the six registers are illegal.
package seg_guard_pkg;

    localparam int PRIV_W   = 2;
    localparam int TGT_W    = 3;
    localparam int NUM_SEG  = 6;
    localparam int TGT_SLOTS = 1 << TGT_W;
    localparam int KIND_W   = 3;

    typedef enum logic [TGT_W-1:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_tgt_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_GP   = 2'b01,
        FLT_NP   = 2'b10
    } fault_code_e;

    // Decoded descriptor classification.
    typedef struct packed {
        logic is_sys;
        logic is_code;
        logic is_data;
        logic conforming;
        logic readable;
        logic writable;
    } desc_class_t;

    // Privilege comparison results.
    typedef struct packed {
        logic dpl_ge_floor;
        logic dpl_eq_cpl;
        logic rpl_eq_cpl;
    } priv_flags_t;

endpackage

// File: rtl/seg_sel_decode.sv
// Module: detects a null selector (index zero in the global table).
// Assumes the table indicator selects the local table when set.
module seg_sel_decode #(
    parameter int IDX_W = 13
) (
    input  logic [IDX_W-1:0] sel_index,
    input  logic             sel_ti,
    output logic             sel_null
);

    // Null test: zero index and global table.
    always_comb begin
        sel_null = (sel_index == '0) && !sel_ti;
    end

endmodule

// File: rtl/seg_desc_classify.sv
// Module: turns raw descriptor attribute bits into a classification record.
// Assumes kind[2]=executable, kind[1]=conforming (code) / expand-down (data),
// kind[0]=readable (code) / writable (data); only meaningful for user descriptors.
module seg_desc_classify
    import seg_guard_pkg::*;
(
    input  logic              desc_user,
    input  logic [KIND_W-1:0] desc_kind,
    output desc_class_t       cls
);

    // Classification of system, code and data descriptors.
    always_comb begin
        cls.is_sys     = !desc_user;
        cls.is_code    = desc_user && desc_kind[2];
        cls.is_data    = desc_user && !desc_kind[2];
        cls.conforming = desc_user && desc_kind[2] && desc_kind[1];
        cls.readable   = desc_user && desc_kind[2] && desc_kind[0];
        cls.writable   = desc_user && !desc_kind[2] && desc_kind[0];
    end

endmodule

// File: rtl/seg_priv_compare.sv
// Module: privilege comparisons shared by the stack and data rules.
// Assumes a larger number means a less privileged level.
module seg_priv_compare
    import seg_guard_pkg::*;
(
    input  logic [PRIV_W-1:0] cur_cpl,
    input  logic [PRIV_W-1:0] sel_rpl,
    input  logic [PRIV_W-1:0] desc_dpl,
    output priv_flags_t       prv
);

    logic [PRIV_W-1:0] floor_lvl;

    // Effective floor is the less privileged of CPL and RPL.
    always_comb begin
        floor_lvl = (cur_cpl > sel_rpl) ? cur_cpl : sel_rpl;
    end

    // Comparison flags.
    always_comb begin
        prv.dpl_ge_floor = (desc_dpl >= floor_lvl);
        prv.dpl_eq_cpl   = (desc_dpl == cur_cpl);
        prv.rpl_eq_cpl   = (sel_rpl == cur_cpl);
    end

endmodule

// File: rtl/seg_rule_matrix.sv
// Module: one rule lane per target slot; each lane flags a protection fault
// and whether the present check is waived. Slots past the six registers always fault.
// Assumes inputs are already decoded by the selector and descriptor stages.
module seg_rule_matrix
    import seg_guard_pkg::*;
#(
    parameter int SLOTS = TGT_SLOTS
) (
    input  logic             sel_null,
    input  desc_class_t      cls,
    input  priv_flags_t      prv,
    output logic [SLOTS-1:0] gp_vec,
    output logic [SLOTS-1:0] np_waive
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g == int'(SEG_CS)) begin : g_code
            // CS lane: code descriptors only, null never allowed.
            always_comb begin
                gp_vec[g]   = sel_null || !cls.is_code;
                np_waive[g] = 1'b0;
            end
        end else if (g == int'(SEG_SS)) begin : g_stack
            // SS lane: writable data at exactly the current privilege.
            always_comb begin
                gp_vec[g]   = sel_null || !cls.is_data || !cls.writable
                              || !prv.dpl_eq_cpl || !prv.rpl_eq_cpl;
                np_waive[g] = 1'b0;
            end
        end else if (g < NUM_SEG) begin : g_data
            // Data lane: null accepted; system and execute-only rejected; privilege floor.
            always_comb begin
                if (sel_null) begin
                    gp_vec[g] = 1'b0;
                end else begin
                    gp_vec[g] = cls.is_sys
                                || (cls.is_code && !cls.readable)
                                || ((cls.is_data || cls.conforming) && !prv.dpl_ge_floor);
                end
                np_waive[g] = sel_null;
            end
        end else begin : g_illegal
            // Unused target codes: always a protection fault.
            always_comb begin
                gp_vec[g]   = 1'b1;
                np_waive[g] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/seg_cpl_reg.sv
// Module: holds the current privilege level; loads a new value on commit.
// Assumes commit is asserted only for an accepted code-segment load.
module seg_cpl_reg
    import seg_guard_pkg::*;
#(
    parameter logic [PRIV_W-1:0] RESET_CPL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [PRIV_W-1:0] next_cpl,
    output logic [PRIV_W-1:0] cpl
);

    // Privilege register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl <= RESET_CPL;
        end else if (commit) begin
            cpl <= next_cpl;
        end
    end

endmodule

// File: rtl/seg_load_guard.sv
// Module: top of the segment register load checker. Combines selector and
// descriptor decode with per-target rules to produce a same-cycle verdict,
// and commits a new CPL when a CS load is accepted.
// Assumes the descriptor has already been fetched and is stable with load_valid.
module seg_load_guard
    import seg_guard_pkg::*;
#(
    parameter int                IDX_W     = 13,
    parameter logic [PRIV_W-1:0] RESET_CPL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_valid,
    input  logic [2:0]       seg_target,
    input  logic [IDX_W-1:0] sel_index,
    input  logic             sel_ti,
    input  logic [1:0]       sel_rpl,
    input  logic             desc_user,
    input  logic [2:0]       desc_kind,
    input  logic [1:0]       desc_dpl,
    input  logic             desc_present,
    output logic             load_ok,
    output logic             fault,
    output logic [1:0]       fault_code,
    output logic [1:0]       cpl
);

    logic                 sel_null;
    desc_class_t          cls;
    priv_flags_t          prv;
    logic [TGT_SLOTS-1:0] gp_vec;
    logic [TGT_SLOTS-1:0] np_waive;
    logic                 lane_gp;
    logic                 lane_waive;
    fault_code_e          verdict;
    logic                 cpl_commit;

    seg_sel_decode #(.IDX_W(IDX_W)) i_sel (
        .sel_index (sel_index),
        .sel_ti    (sel_ti),
        .sel_null  (sel_null)
    );

    seg_desc_classify i_cls (
        .desc_user (desc_user),
        .desc_kind (desc_kind),
        .cls       (cls)
    );

    seg_priv_compare i_prv (
        .cur_cpl  (cpl),
        .sel_rpl  (sel_rpl),
        .desc_dpl (desc_dpl),
        .prv      (prv)
    );

    seg_rule_matrix #(.SLOTS(TGT_SLOTS)) i_rules (
        .sel_null (sel_null),
        .cls      (cls),
        .prv      (prv),
        .gp_vec   (gp_vec),
        .np_waive (np_waive)
    );

    // Pick the lane of the addressed target.
    always_comb begin
        lane_gp    = gp_vec[seg_target];
        lane_waive = np_waive[seg_target];
    end

    // Verdict: protection faults outrank the present check.
    always_comb begin
        if (!load_valid) begin
            verdict = FLT_NONE;
        end else if (lane_gp) begin
            verdict = FLT_GP;
        end else if (!lane_waive && !desc_present) begin
            verdict = FLT_NP;
        end else begin
            verdict = FLT_NONE;
        end
    end

    // Output drive and CPL commit request.
    always_comb begin
        fault_code = verdict;
        fault      = load_valid && (verdict != FLT_NONE);
        load_ok    = load_valid && (verdict == FLT_NONE);
        cpl_commit = load_ok && (seg_target == SEG_CS);
    end

    seg_cpl_reg #(.RESET_CPL(RESET_CPL)) i_cpl (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (cpl_commit),
        .next_cpl (desc_dpl),
        .cpl      (cpl)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> (!load_ok && !fault && fault_code == 2'b00)); // R1

    AST_ILLEGAL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && seg_target > 3'd5) |-> (fault && fault_code == 2'b01)); // R2

    AST_NULL_DATA_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && sel_index == '0 && !sel_ti
         && (seg_target == 3'd0 || seg_target == 3'd3
             || seg_target == 3'd4 || seg_target == 3'd5)) |-> load_ok); // R3

    AST_CS_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && seg_target == 3'd1) |-> (desc_user && desc_kind[2])); // R4

    AST_CPL_FOLLOWS_DPL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && seg_target == 3'd1) |=> (cpl == $past(desc_dpl))); // R5

    AST_CPL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok && seg_target == 3'd1) |=> $stable(cpl)); // R5

    AST_SS_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && seg_target == 3'd2) |-> (desc_user && !desc_kind[2] && desc_kind[0])); // R6

    AST_SS_PRIV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && seg_target == 3'd2) |-> (desc_dpl == cpl && sel_rpl == cpl)); // R7

    AST_DATA_NO_SYSTEM: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && !(sel_index == '0 && !sel_ti)
         && (seg_target == 3'd0 || seg_target == 3'd3
             || seg_target == 3'd4 || seg_target == 3'd5)) |-> desc_user); // R8

    AST_DATA_PRIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && !(sel_index == '0 && !sel_ti) && desc_user
         && (!desc_kind[2] || desc_kind[1])
         && (seg_target == 3'd0 || seg_target == 3'd3
             || seg_target == 3'd4 || seg_target == 3'd5))
        |-> (desc_dpl >= cpl && desc_dpl >= sel_rpl)); // R9

    AST_NP_ONLY_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 2'b10) |-> !desc_present); // R10

endmodule

// File: tb/test_seg_load_guard.sv
// Bench: vector table walked by one loop, then directed reset and corner tests.
module test_seg_load_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_valid;
    logic [2:0]  seg_target;
    logic [12:0] sel_index;
    logic        sel_ti;
    logic [1:0]  sel_rpl;
    logic        desc_user;
    logic [2:0]  desc_kind;
    logic [1:0]  desc_dpl;
    logic        desc_present;
    logic        load_ok;
    logic        fault;
    logic [1:0]  fault_code;
    logic [1:0]  cpl;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    seg_load_guard i_seg_load_guard (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .seg_target(seg_target),
        .sel_index(sel_index), .sel_ti(sel_ti), .sel_rpl(sel_rpl),
        .desc_user(desc_user), .desc_kind(desc_kind), .desc_dpl(desc_dpl),
        .desc_present(desc_present), .load_ok(load_ok), .fault(fault),
        .fault_code(fault_code), .cpl(cpl)
    );

    // Vector: pre_cpl(2) tgt(3) idx(4) ti(1) rpl(2) user(1) kind(3) dpl(2) present(1) exp_code(2) req(5)
    localparam int NV = 31;
    localparam logic [25:0] VECS [0:NV-1] = '{
        {2'd0,3'd3,4'd1,1'b0,2'd0,1'b1,3'b001,2'd0,1'b1,2'b00,5'd8},  // R8 plain data accepted
        {2'd0,3'd3,4'd0,1'b0,2'd0,1'b0,3'b000,2'd0,1'b0,2'b00,5'd3},  // R3 null DS
        {2'd3,3'd4,4'd0,1'b0,2'd3,1'b0,3'b110,2'd0,1'b1,2'b00,5'd3},  // R3 null FS
        {2'd0,3'd1,4'd0,1'b0,2'd0,1'b1,3'b101,2'd0,1'b1,2'b01,5'd3},  // R3 null CS
        {2'd0,3'd2,4'd0,1'b0,2'd0,1'b1,3'b001,2'd0,1'b1,2'b01,5'd3},  // R3 null SS
        {2'd0,3'd3,4'd0,1'b1,2'd0,1'b1,3'b001,2'd0,1'b1,2'b00,5'd3},  // R3 ti=1 not null
        {2'd0,3'd1,4'd2,1'b0,2'd0,1'b1,3'b001,2'd0,1'b1,2'b01,5'd4},  // R4 data into CS
        {2'd0,3'd1,4'd2,1'b0,2'd0,1'b0,3'b101,2'd0,1'b1,2'b01,5'd4},  // R4 system into CS
        {2'd0,3'd1,4'd2,1'b0,2'd0,1'b1,3'b100,2'd0,1'b1,2'b00,5'd4},  // R4 exec-only code OK
        {2'd0,3'd1,4'd2,1'b0,2'd0,1'b1,3'b101,2'd0,1'b0,2'b10,5'd10}, // R10 CS not present
        {2'd0,3'd2,4'd3,1'b0,2'd0,1'b1,3'b001,2'd0,1'b1,2'b00,5'd6},  // R6 SS writable OK
        {2'd0,3'd2,4'd3,1'b0,2'd0,1'b1,3'b000,2'd0,1'b1,2'b01,5'd6},  // R6 SS read-only
        {2'd0,3'd2,4'd3,1'b0,2'd0,1'b1,3'b101,2'd0,1'b1,2'b01,5'd6},  // R6 SS code
        {2'd3,3'd2,4'd3,1'b0,2'd3,1'b1,3'b001,2'd3,1'b1,2'b00,5'd7},  // R7 SS at 3 OK
        {2'd3,3'd2,4'd3,1'b0,2'd3,1'b1,3'b001,2'd2,1'b1,2'b01,5'd7},  // R7 SS dpl mismatch
        {2'd3,3'd2,4'd3,1'b0,2'd2,1'b1,3'b001,2'd3,1'b1,2'b01,5'd7},  // R7 SS rpl mismatch
        {2'd0,3'd2,4'd3,1'b0,2'd0,1'b1,3'b001,2'd0,1'b0,2'b10,5'd10}, // R10 SS not present
        {2'd0,3'd0,4'd4,1'b0,2'd0,1'b0,3'b001,2'd0,1'b1,2'b01,5'd8},  // R8 system into ES
        {2'd0,3'd5,4'd4,1'b0,2'd0,1'b1,3'b100,2'd0,1'b1,2'b01,5'd8},  // R8 exec-only into GS
        {2'd2,3'd3,4'd5,1'b0,2'd0,1'b1,3'b001,2'd1,1'b1,2'b01,5'd9},  // R9 dpl below cpl
        {2'd1,3'd3,4'd5,1'b0,2'd2,1'b1,3'b001,2'd1,1'b1,2'b01,5'd9},  // R9 dpl below rpl
        {2'd1,3'd3,4'd5,1'b0,2'd2,1'b1,3'b001,2'd2,1'b1,2'b00,5'd9},  // R9 dpl at floor
        {2'd3,3'd0,4'd5,1'b0,2'd3,1'b1,3'b101,2'd0,1'b1,2'b00,5'd9},  // R9 nonconforming no test
        {2'd3,3'd3,4'd5,1'b0,2'd0,1'b1,3'b111,2'd0,1'b1,2'b01,5'd9},  // R9 conforming below cpl
        {2'd0,3'd4,4'd5,1'b0,2'd1,1'b1,3'b111,2'd3,1'b1,2'b00,5'd9},  // R9 conforming OK
        {2'd0,3'd0,4'd6,1'b0,2'd0,1'b1,3'b001,2'd0,1'b0,2'b10,5'd10}, // R10 ES not present
        {2'd3,3'd3,4'd6,1'b0,2'd0,1'b1,3'b001,2'd0,1'b0,2'b01,5'd10}, // R10 GP beats NP
        {2'd0,3'd6,4'd7,1'b0,2'd0,1'b1,3'b001,2'd0,1'b1,2'b01,5'd2},  // R2 code 6
        {2'd0,3'd7,4'd7,1'b0,2'd0,1'b1,3'b101,2'd0,1'b1,2'b01,5'd2},  // R2 code 7
        {2'd0,3'd3,4'd0,1'b0,2'd0,1'b1,3'b001,2'd0,1'b0,2'b00,5'd3},  // R3 null skips present
        {2'd0,3'd5,4'd8,1'b0,2'd0,1'b1,3'b110,2'd0,1'b1,2'b01,5'd8}   // R8 conforming exec-only
    };

    // Record one comparison.
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        load_valid = 1'b0; seg_target = 3'd0; sel_index = '0; sel_ti = 1'b0;
        sel_rpl = 2'd0; desc_user = 1'b0; desc_kind = 3'd0; desc_dpl = 2'd0; desc_present = 1'b0;
    endtask

    // Present one request at a falling edge; sample verdict before the rising edge,
    // then the privilege just after it.
    task automatic drive(input logic [2:0] t, input logic [3:0] idx, input logic ti,
                         input logic [1:0] rpl, input logic u, input logic [2:0] k,
                         input logic [1:0] dpl, input logic p,
                         output logic ok, output logic flt, output logic [1:0] code);
        @(negedge clk);
        load_valid = 1'b1; seg_target = t; sel_index = 13'(idx); sel_ti = ti;
        sel_rpl = rpl; desc_user = u; desc_kind = k; desc_dpl = dpl; desc_present = p;
        #2;
        ok = load_ok; flt = fault; code = fault_code;
        @(posedge clk); #1;
        idle();
    endtask

    logic [1:0] model_cpl;

    initial begin
        logic ok, flt;
        logic [1:0] code;
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        model_cpl = 2'd0;

        // R5 reset value, R1 idle outputs
        chk("R5", "cpl after reset", int'(cpl), 0);
        @(negedge clk); #2;
        chk("R1", "load_ok idle", int'(load_ok), 0);
        chk("R1", "fault idle", int'(fault), 0);
        chk("R1", "code idle", int'(fault_code), 0);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            string rq;
            v = VECS[i];
            rq = $sformatf("R%0d vec%0d", int'(v[4:0]), i);
            if (v[25:24] != model_cpl) begin
                drive(3'd1, 4'd9, 1'b0, 2'd0, 1'b1, 3'b101, v[25:24], 1'b1, ok, flt, code);
                chk("R5", "setup CS accept", int'(ok), 1);
                chk("R5", "setup cpl", int'(cpl), int'(v[25:24]));
                model_cpl = v[25:24];
            end
            drive(v[23:21], v[20:17], v[16], v[15:14], v[13], v[12:10], v[9:8], v[7],
                  ok, flt, code);
            chk(rq, "fault_code", int'(code), int'(v[6:5]));
            chk("R11", "load_ok vs code", int'(ok), (v[6:5] == 2'b00) ? 1 : 0);
            chk("R11", "fault vs code", int'(flt), (v[6:5] != 2'b00) ? 1 : 0);
            if (v[23:21] == 3'd1 && v[6:5] == 2'b00) model_cpl = v[9:8];
            chk("R5", "cpl after vector", int'(cpl), int'(model_cpl));
        end

        // R1: code load with valid low leaves cpl alone
        @(negedge clk);
        seg_target = 3'd1; sel_index = 13'd4; desc_user = 1'b1; desc_kind = 3'b101;
        desc_dpl = 2'd2; desc_present = 1'b1;
        #2;
        chk("R1", "no accept while invalid", int'(load_ok), 0);
        @(posedge clk); #1;
        chk("R1", "cpl unchanged while invalid", int'(cpl), int'(model_cpl));
        idle();

        // R5: accepted CS at 2, then rejected CS at 3 keeps 2
        drive(3'd1, 4'd4, 1'b0, 2'd0, 1'b1, 3'b101, 2'd2, 1'b1, ok, flt, code);
        chk("R5", "cpl takes dpl 2", int'(cpl), 2);
        drive(3'd1, 4'd4, 1'b0, 2'd0, 1'b1, 3'b001, 2'd3, 1'b1, ok, flt, code);
        chk("R4", "data into CS rejected", int'(code), 1);
        chk("R5", "cpl held after reject", int'(cpl), 2);
        drive(3'd1, 4'd4, 1'b0, 2'd0, 1'b1, 3'b101, 2'd3, 1'b0, ok, flt, code);
        chk("R10", "CS absent code", int'(code), 2);
        chk("R5", "cpl held after absent", int'(cpl), 2);

        // R5: reset returns cpl to 0
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        chk("R5", "cpl after second reset", int'(cpl), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule